// File: doc/BRIEF.md
# LCD 16/12-bit pixel unpacker

This block sits between the frame-buffer fetch and the pixel pipeline of a colour LCD controller. It takes one 32-bit frame-buffer word at a time on a valid/ready stream. It splits the word into two halfword pixels and widens each one to 24-bit RGB with 8 bits per channel. The pixels leave on a second valid/ready stream: the pixel from the low halfword comes first, then the pixel from the high halfword.

Three packed source formats are decoded: 5551 (three 5-bit channels and an intensity bit that is ignored), 565, and 444 padded to a halfword. The format comes from a 3-bit depth code. The channel order is chosen by a BGR flag. Frame buffers stored big-endian are handled by reversing the bytes of each word before it is split.

A legacy input selects the older controller variant. In that variant only depth code 4 is native. A 2-bit external mux value then decides whether code 4 is read as 5551, as 565 in the order the BGR flag gives, or as 565 with blue and red forced to the BGR order. The depth code, BGR flag, mux value and byte-order selection are all captured when a word is accepted, so both pixels of a word share one configuration.

Top module: `pix16_unpack`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of a word, pix_valid_o is low and word_ready_o is high. The next pixel produced comes from the low halfword of the next accepted word.
- R2: Each accepted word yields exactly two pixels. Bits [15:0] are unpacked first and bits [31:16] second.
- R3: With legacy_i low and bpp_i = 4 the format is 5551. The fields are low = [4:0], mid = [9:5] and high = [14:10], each shifted left by 3. Bit 15 has no effect.
- R4: With legacy_i low and bpp_i = 6 the format is 565. The fields are low = [4:0] and high = [15:11], each shifted left by 3, and mid = [10:5] shifted left by 2.
- R5: With legacy_i low and bpp_i = 7 the format is 444. The fields are low = [3:0], mid = [7:4] and high = [11:8], each shifted left by 4. Bits [15:12] have no effect.
- R6: pix_o is {red[23:16], green[15:8], blue[7:0]}, and green is always the mid field. With bgr_i = 0 the low field is red and the high field is blue. With bgr_i = 1 the low field is blue and the high field is red.
- R7: With legacy_i high and bpp_i = 4, mux_i selects the format. A value of 1 gives 5551. A value of 3 gives 565 with the low field as blue, whatever bgr_i is. Values 0 and 2 give 565 and follow bgr_i.
- R8: Any other combination is unsupported: bpp_i other than 4, 6 or 7 with legacy_i low, or bpp_i other than 4 with legacy_i high. The word is still consumed, and both of its pixels are 24'h000000.
- R9: When endian_i is nonzero, the four bytes of the word are reversed (byte 0 swapped with byte 3, byte 1 with byte 2) before unpacking. When endian_i is 0 the word is used as received.
- R10: While pix_valid_o is high and pix_ready_i is low, pix_o and pix_valid_o hold their values.
- R11: word_ready_o is high only when no pixel of an earlier word is still pending. A word accepted in one cycle shows its first pixel on pix_valid_o in the next cycle.
- R12: bpp_i, bgr_i, legacy_i, mux_i and endian_i are sampled when the word is accepted. A change while that word's pixels are pending does not affect them.
- R13: Every valid pixel has zero fill in its low channel bits: red [18:16], green [9:8] and blue [2:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bpp_i | input | 3 | Colour depth code |
| bgr_i | input | 1 | Channel order flag: 1 puts the low field on blue |
| legacy_i | input | 1 | Selects the older variant, where code 4 is steered by the mux |
| mux_i | input | 2 | External format mux value, used in the legacy variant |
| endian_i | input | 2 | Byte-order selection; any nonzero value reverses bytes |
| word_valid_i | input | 1 | Frame-buffer word valid |
| word_i | input | 32 | Frame-buffer word |
| word_ready_o | output | 1 | Block can accept a word |
| pix_valid_o | output | 1 | Pixel valid |
| pix_ready_i | input | 1 | Downstream takes the pixel |
| pix_o | output | 24 | RGB pixel, red in the top byte |

## Verification
The assertions check on every cycle the stream rules: a stalled pixel holds steady, an accepted word always produces a pixel in the next cycle, and the input reopens only after a pixel handshake. They also check the zero fill of the low channel bits, and that a word accepted in an unsupported mode gives a black pixel. What the assertions cannot show is whether each field lands in the right channel for each format, BGR setting, mux value and byte order. That needs known words with hand-computed results, and the bench supplies them. The bench scenarios also cover configuration changes while a word is pending, and a reset that lands between the two pixels of a word.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int NBYTES = WORD_W / 8;

  localparam logic [2:0] BPP_5551 = 3'd4;
  localparam logic [2:0] BPP_565  = 3'd6;
  localparam logic [2:0] BPP_444  = 3'd7;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_5551 = 2'd1,
    FMT_565  = 2'd2,
    FMT_444  = 2'd3
  } fmt_e;
endpackage

// File: rtl/pix_fmt_decode.sv
module pix_fmt_decode
  import pix_unpack_pkg::*;
(
  input  logic [2:0] bpp_i,
  input  logic       legacy_i,
  input  logic [1:0] mux_i,
  input  logic       bgr_i,
  output fmt_e       fmt_o,
  output logic       bgr_o
);
  always_comb begin
    fmt_o = FMT_NONE;
    bgr_o = bgr_i;
    if (legacy_i) begin
      if (bpp_i == BPP_5551) begin
        unique case (mux_i)
          2'd1: fmt_o = FMT_5551;
          2'd3: begin
            fmt_o = FMT_565;
            bgr_o = 1'b1;
          end
          default: fmt_o = FMT_565;
        endcase
      end
    end else begin
      unique case (bpp_i)
        BPP_5551: fmt_o = FMT_5551;
        BPP_565:  fmt_o = FMT_565;
        BPP_444:  fmt_o = FMT_444;
        default:  fmt_o = FMT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pix_word_buf.sv
module pix_word_buf
  import pix_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              swap_i,
  input  fmt_e              fmt_i,
  input  logic              bgr_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [HALF_W-1:0] out_half_o,
  output fmt_e              out_fmt_o,
  output logic              out_bgr_o,
  input  logic              out_ready_i
);
  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] word_q;
  logic              full_q;
  logic              phase_q;
  fmt_e              fmt_q;
  logic              bgr_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = swap_i ? in_word_i[8*(NBYTES-1-b) +: 8] : in_word_i[8*b +: 8];
  end

  assign in_ready_o  = !full_q;
  assign out_valid_o = full_q;
  assign out_half_o  = phase_q ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
  assign out_fmt_o   = fmt_q;
  assign out_bgr_o   = bgr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      full_q  <= 1'b0;
      phase_q <= 1'b0;
      fmt_q   <= FMT_NONE;
      bgr_q   <= 1'b0;
    end else if (!full_q) begin
      if (in_valid_i) begin
        word_q  <= swapped;
        fmt_q   <= fmt_i;
        bgr_q   <= bgr_i;
        full_q  <= 1'b1;
        phase_q <= 1'b0;
      end
    end else if (out_ready_i) begin
      if (phase_q) begin
        full_q  <= 1'b0;
        phase_q <= 1'b0;
      end else begin
        phase_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_expand.sv
module pix_expand
  import pix_unpack_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  fmt_e              fmt_i,
  input  logic              bgr_i,
  output logic [PIX_W-1:0]  rgb_o
);
  logic [CH_W-1:0] lo, mid, hi;

  always_comb begin
    lo  = '0;
    mid = '0;
    hi  = '0;
    unique case (fmt_i)
      FMT_5551: begin
        lo  = {half_i[4:0],   3'b0};
        mid = {half_i[9:5],   3'b0};
        hi  = {half_i[14:10], 3'b0};
      end
      FMT_565: begin
        lo  = {half_i[4:0],   3'b0};
        mid = {half_i[10:5],  2'b0};
        hi  = {half_i[15:11], 3'b0};
      end
      FMT_444: begin
        lo  = {half_i[3:0],  4'b0};
        mid = {half_i[7:4],  4'b0};
        hi  = {half_i[11:8], 4'b0};
      end
      default: ;
    endcase
    rgb_o = bgr_i ? {hi, mid, lo} : {lo, mid, hi};
  end
endmodule

// File: rtl/pix16_unpack.sv
module pix16_unpack
  import pix_unpack_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  bpp_i,
  input  logic        bgr_i,
  input  logic        legacy_i,
  input  logic [1:0]  mux_i,
  input  logic [1:0]  endian_i,
  input  logic        word_valid_i,
  input  logic [31:0] word_i,
  output logic        word_ready_o,
  output logic        pix_valid_o,
  input  logic        pix_ready_i,
  output logic [23:0] pix_o
);
  fmt_e              dec_fmt, buf_fmt;
  logic              dec_bgr, buf_bgr;
  logic [HALF_W-1:0] buf_half;

  pix_fmt_decode u_dec (
    .bpp_i    (bpp_i),
    .legacy_i (legacy_i),
    .mux_i    (mux_i),
    .bgr_i    (bgr_i),
    .fmt_o    (dec_fmt),
    .bgr_o    (dec_bgr)
  );

  pix_word_buf u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (word_valid_i),
    .in_word_i   (word_i),
    .swap_i      (|endian_i),
    .fmt_i       (dec_fmt),
    .bgr_i       (dec_bgr),
    .in_ready_o  (word_ready_o),
    .out_valid_o (pix_valid_o),
    .out_half_o  (buf_half),
    .out_fmt_o   (buf_fmt),
    .out_bgr_o   (buf_bgr),
    .out_ready_i (pix_ready_i)
  );

  pix_expand u_exp (
    .half_i (buf_half),
    .fmt_i  (buf_fmt),
    .bgr_i  (buf_bgr),
    .rgb_o  (pix_o)
  );
endmodule

// File: rtl/pix16_unpack_chk.sv
module pix16_unpack_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  bpp_i,
  input logic        legacy_i,
  input logic        word_valid_i,
  input logic        word_ready_o,
  input logic        pix_valid_o,
  input logic        pix_ready_i,
  input logic [23:0] pix_o
);
  AST_PIX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_o)); // R10

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o |=> pix_valid_o && !word_ready_o); // R11

  AST_REOPEN_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !word_ready_o && !pix_ready_i |=> !word_ready_o); // R2

  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_o[18:16] == 3'b0) && (pix_o[9:8] == 2'b0) && (pix_o[2:0] == 3'b0)); // R13

  AST_UNSUPPORTED_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o && !legacy_i && (bpp_i == 3'd5) |=> pix_o == 24'h0); // R8
endmodule

bind pix16_unpack pix16_unpack_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bpp_i        (bpp_i),
  .legacy_i     (legacy_i),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .pix_valid_o  (pix_valid_o),
  .pix_ready_i  (pix_ready_i),
  .pix_o        (pix_o)
);

// File: tb/pix16_unpack_tb.sv
`timescale 1ns/1ps
module pix16_unpack_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  bpp_i = 3'd4;
  logic        bgr_i = 1'b0;
  logic        legacy_i = 1'b0;
  logic [1:0]  mux_i = 2'd0;
  logic [1:0]  endian_i = 2'd0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_ready_o;
  logic        pix_valid_o;
  logic        pix_ready_i = 1'b1;
  logic [23:0] pix_o;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk_i = ~clk_i;

  pix16_unpack u_dut (.*);

  typedef struct packed {
    logic [2:0]  bpp;
    logic        bgr;
    logic        legacy;
    logic [1:0]  mux;
    logic [1:0]  endian;
    logic [31:0] word;
    logic [23:0] lo;
    logic [23:0] hi;
    int          req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 1'b0, 1'b0, 2'd0, 2'd0, 32'h8001FFFF, 24'hF8F8F8, 24'h080000, 3},  // R3 intensity ignored
    '{3'd4, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7C0003E0, 24'h00F800, 24'hF80000, 6},  // R6 5551 bgr
    '{3'd6, 1'b0, 1'b0, 2'd0, 2'd0, 32'h07E0F800, 24'h0000F8, 24'h00FC00, 4},  // R4
    '{3'd6, 1'b1, 1'b0, 2'd0, 2'd0, 32'h8421001F, 24'h0000F8, 24'h808408, 6},  // R6 565 bgr
    '{3'd7, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0ABCF123, 24'h302010, 24'hC0B0A0, 5},  // R5 pad ignored, R2 order
    '{3'd7, 1'b0, 1'b0, 2'd0, 2'd1, 32'h23F1BC0A, 24'h302010, 24'hC0B0A0, 9},  // R9 endian 1
    '{3'd6, 1'b0, 1'b0, 2'd0, 2'd2, 32'h00F8E007, 24'h0000F8, 24'h00FC00, 9},  // R9 endian 2
    '{3'd4, 1'b0, 1'b1, 2'd1, 2'd0, 32'h8001FFFF, 24'hF8F8F8, 24'h080000, 7},  // R7 mux 1
    '{3'd4, 1'b0, 1'b1, 2'd3, 2'd0, 32'h8421001F, 24'h0000F8, 24'h808408, 7},  // R7 mux 3 forced
    '{3'd4, 1'b0, 1'b1, 2'd0, 2'd0, 32'h07E0F800, 24'h0000F8, 24'h00FC00, 7},  // R7 mux 0
    '{3'd4, 1'b1, 1'b1, 2'd2, 2'd0, 32'h8421001F, 24'h0000F8, 24'h808408, 7},  // R7 mux 2 bgr
    '{3'd4, 1'b0, 1'b1, 2'd2, 2'd0, 32'h8421001F, 24'hF80000, 24'h088480, 7},  // R7 mux 2 rgb
    '{3'd5, 1'b0, 1'b0, 2'd0, 2'd0, 32'hFFFFFFFF, 24'h000000, 24'h000000, 8},  // R8
    '{3'd6, 1'b0, 1'b1, 2'd0, 2'd0, 32'hFFFFFFFF, 24'h000000, 24'h000000, 8},  // R8 legacy
    '{3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 32'h12345678, 24'h000000, 24'h000000, 8}   // R8
  };

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic [2:0] b, logic g, logic l, logic [1:0] m, logic [1:0] e);
    bpp_i = b; bgr_i = g; legacy_i = l; mux_i = m; endian_i = e;
  endtask

  // at a negedge: present word, accept on next posedge, return at following negedge
  task automatic push(logic [31:0] w);
    word_i = w;
    word_valid_i = 1'b1;
    @(negedge clk_i);
    word_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after reset", {23'b0, pix_valid_o}, 24'd0);
    check("R1 ready after reset", {23'b0, word_ready_o}, 24'd1);

    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].bpp, VECS[i].bgr, VECS[i].legacy, VECS[i].mux, VECS[i].endian);
      check($sformatf("R%0d ready v%0d", VECS[i].req, i), {23'b0, word_ready_o}, 24'd1);
      push(VECS[i].word);
      check($sformatf("R%0d valid v%0d", VECS[i].req, i), {23'b0, pix_valid_o}, 24'd1);
      check($sformatf("R%0d low v%0d", VECS[i].req, i), pix_o, VECS[i].lo);
      @(negedge clk_i);
      check($sformatf("R%0d high v%0d", VECS[i].req, i), pix_o, VECS[i].hi);
      @(negedge clk_i);
    end

    // R10 / R11: stall holds the pixel and blocks input
    set_cfg(3'd6, 1'b0, 1'b0, 2'd0, 2'd0);
    pix_ready_i = 1'b0;
    push(32'h07E0F800);
    check("R11 ready low while held", {23'b0, word_ready_o}, 24'd0);
    check("R10 first pixel", pix_o, 24'h0000F8);
    @(negedge clk_i);
    check("R10 pixel held", pix_o, 24'h0000F8);
    check("R10 valid held", {23'b0, pix_valid_o}, 24'd1);
    check("R11 ready still low", {23'b0, word_ready_o}, 24'd0);
    pix_ready_i = 1'b1;
    @(negedge clk_i);
    check("R2 second pixel", pix_o, 24'h00FC00);
    @(negedge clk_i);
    check("R2 empty after two", {23'b0, pix_valid_o}, 24'd0);
    check("R11 ready again", {23'b0, word_ready_o}, 24'd1);

    // R12: config change after accept does not affect pending pixels
    set_cfg(3'd6, 1'b0, 1'b0, 2'd0, 2'd0);
    push(32'h8421001F);
    set_cfg(3'd7, 1'b1, 1'b1, 2'd3, 2'd1);
    check("R12 low pixel", pix_o, 24'hF80000);
    @(negedge clk_i);
    check("R12 high pixel", pix_o, 24'h088480);
    @(negedge clk_i);

    // R1: reset between the two pixels of a word
    set_cfg(3'd6, 1'b0, 1'b0, 2'd0, 2'd0);
    pix_ready_i = 1'b0;
    push(32'h07E0F800);
    pix_ready_i = 1'b1;
    @(negedge clk_i);
    pix_ready_i = 1'b0;
    check("R1 mid-word high shown", pix_o, 24'h00FC00);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 valid cleared", {23'b0, pix_valid_o}, 24'd0);
    check("R1 ready in reset", {23'b0, word_ready_o}, 24'd1);
    rst_ni = 1'b1;
    pix_ready_i = 1'b1;
    @(negedge clk_i);
    push(32'h8421001F);
    check("R1 restart low half", pix_o, 24'hF80000);
    @(negedge clk_i);
    check("R1 restart high half", pix_o, 24'h088480);
    @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule